// File: doc/BRIEF.md
# Banked ROM/RAM Chip-Select Steering

This block produces the chip selects for a banked memory expansion. A 128 KB RAM is split into sixteen 8 KB banks. A four-bit bank register picks the active bank, and the CPU writes that register through a write strobe. Any of the four lowest banks can be served by a dedicated ROM instead of the RAM. A static configuration bit for each of those banks chooses between the two. Whenever the CPU addresses the expansion window, exactly one device is selected: the ROM that matches the bank, or the RAM.

Each select output is modelled as an open-drain pin with two signals: a drive flag and a data value that is always zero. When the flag is 1, the pin is pulled to ground. When the flag is 0, the pin floats and an external pull-up makes it read high. The output cells never drive a line high, so the lines can be tied together on the board. The bank register value goes out unchanged as the RAM's upper address bits.

Internally, a decoder sorts each cycle into one of three named targets. TGT_IDLE means no window access is in progress. TGT_LOW means an access to one of banks 0–3. TGT_HIGH means an access to one of banks 4–15. The decoder moves between targets combinationally, every cycle: on window access or release, and whenever a bank write takes effect. It then asserts one of five internal active-low enables. A steering stage routes each low-bank enable to its ROM or to the RAM.

Top module: `bank_cs_steer`

## Requirements
- R1: After reset the bank register holds 0, so `ram_bank` is 4'h0.
- R2: When `bank_wr` is 1 at a rising clock edge, `ram_bank` takes the value of `bank_wdata` after that edge. With `bank_wr` at 0, the value is held.
- R3: While `win_acc` is 0, no select drive flag (`rom_drv`, `ram_drv`) is 1, whatever the bank and configuration.
- R4: During an access to any bank from 4 to 15, `ram_drv` is 1 and every `rom_drv` bit is 0, regardless of `cfg_ram`.
- R5: During an access to bank n (0–3) with `cfg_ram[n]` = 0, only `rom_drv[n]` is 1 (bit n of the ROM drive vector), and `ram_drv` is 0.
- R6: During an access to bank n (0–3) with `cfg_ram[n]` = 1, `ram_drv` is 1 and every `rom_drv` bit is 0.
- R7: At most one drive flag is 1 in any cycle, and exactly one is 1 whenever `win_acc` is 1.
- R8: `rom_dout` and `ram_dout` are always 0. With a pull-up model (a pin is low when its drive flag is 1 and high otherwise), each resolved pin level is low exactly when its select is asserted.
- R9: During an access, the configuration bits of banks other than the addressed one have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_wr | input | 1 | Bank register write strobe |
| bank_wdata | input | 4 | New bank number |
| win_acc | input | 1 | CPU is addressing the expansion window |
| cfg_ram | input | 4 | Per low bank: 1 = serve from RAM, 0 = serve from its ROM |
| rom_drv | output | 4 | Per ROM select pin: 1 = pull low, 0 = release |
| rom_dout | output | 4 | Data for ROM select pins, constant 0 |
| ram_drv | output | 1 | RAM select pin: 1 = pull low, 0 = release |
| ram_dout | output | 1 | Data for RAM select pin, constant 0 |
| ram_bank | output | 4 | RAM upper address bits (A16..A13) from the bank register |

## Verification
All 16 banks are swept against all 16 configuration patterns, once with the window active and once idle. This separates the ROM case from the redirected-RAM case from the fixed-RAM case for every bank, and shows that an idle window masks every one of them. A walk over the configuration bits, with the addressed bank's own bit held fixed, exposes any crosstalk from the bits of other banks. Random writes mixed with hold cycles separate correct loading from a register that ignores the strobe or always loads. Random access and configuration traffic then checks the pull-up resolved pin levels against a reference model.

// File: rtl/bank_cs_pkg.sv
package bank_cs_pkg;
    localparam int BANK_W    = 4;
    localparam int ROM_BANKS = 4;

    typedef enum logic [1:0] {
        TGT_IDLE = 2'd0,
        TGT_LOW  = 2'd1,
        TGT_HIGH = 2'd2
    } tgt_e;
endpackage

// File: rtl/bank_reg.sv
module bank_reg #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] bank
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank <= '0;
        else if (wr) bank <= wdata;
    end

    assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> bank == $past(wdata));
    assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(bank));
endmodule

// File: rtl/ce_decode.sv
module ce_decode
    import bank_cs_pkg::*;
#(
    parameter int BANK_W    = 4,
    parameter int ROM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_W-1:0]    bank,
    input  logic                 win,
    output logic [ROM_BANKS:0]   ce_n
);
    localparam int IDX_W = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1;
    localparam logic [BANK_W-1:0] LOW_LIMIT = BANK_W'(ROM_BANKS);

    tgt_e tgt;

    always_comb begin
        if (!win)                 tgt = TGT_IDLE;
        else if (bank < LOW_LIMIT) tgt = TGT_LOW;
        else                      tgt = TGT_HIGH;
    end

    always_comb begin
        ce_n = '1;
        unique case (tgt)
            TGT_IDLE: ce_n = '1;
            TGT_LOW:  ce_n[bank[IDX_W-1:0]] = 1'b0;
            TGT_HIGH: ce_n[ROM_BANKS] = 1'b0;
            default:  ce_n = '1;
        endcase
    end

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !win |-> &ce_n);
    assert_one_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win |-> $countones(~ce_n) == 1);
endmodule

// File: rtl/sel_steer.sv
module sel_steer #(
    parameter int ROM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ROM_BANKS:0]   ce_n,
    input  logic [ROM_BANKS-1:0] cfg_ram,
    output logic [ROM_BANKS-1:0] rom_sel_n,
    output logic                 ram_sel_n
);
    logic [ROM_BANKS-1:0] redirect;

    for (genvar n = 0; n < ROM_BANKS; n++) begin : g_steer
        assign rom_sel_n[n] = ce_n[n] | cfg_ram[n];
        assign redirect[n]  = ~ce_n[n] & cfg_ram[n];
    end

    assign ram_sel_n = ce_n[ROM_BANKS] & ~(|redirect);

    assert_single_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~rom_sel_n, ~ram_sel_n}));
    assert_high_to_ram_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n[ROM_BANKS] |-> (!ram_sel_n && &rom_sel_n));
endmodule

// File: rtl/od_pad.sv
module od_pad (
    input  logic sel_n,
    output logic drv,
    output logic dout
);
    assign drv  = ~sel_n;
    assign dout = 1'b0;
endmodule

// File: rtl/bank_cs_steer.sv
module bank_cs_steer
    import bank_cs_pkg::*;
#(
    parameter int BW = BANK_W,
    parameter int RB = ROM_BANKS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bank_wr,
    input  logic [BW-1:0] bank_wdata,
    input  logic          win_acc,
    input  logic [RB-1:0] cfg_ram,
    output logic [RB-1:0] rom_drv,
    output logic [RB-1:0] rom_dout,
    output logic          ram_drv,
    output logic          ram_dout,
    output logic [BW-1:0] ram_bank
);
    logic [BW-1:0] bank_q;
    logic [RB:0]   ce_n;
    logic [RB-1:0] rom_sel_n;
    logic          ram_sel_n;

    bank_reg #(.BANK_W(BW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr(bank_wr), .wdata(bank_wdata), .bank(bank_q)
    );

    ce_decode #(.BANK_W(BW), .ROM_BANKS(RB)) u_dec (
        .clk(clk), .rst_n(rst_n), .bank(bank_q), .win(win_acc), .ce_n(ce_n)
    );

    sel_steer #(.ROM_BANKS(RB)) u_steer (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cfg_ram(cfg_ram),
        .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n)
    );

    for (genvar n = 0; n < RB; n++) begin : g_rom_pad
        od_pad u_pad (.sel_n(rom_sel_n[n]), .drv(rom_drv[n]), .dout(rom_dout[n]));
    end

    od_pad u_ram_pad (.sel_n(ram_sel_n), .drv(ram_drv), .dout(ram_dout));

    assign ram_bank = bank_q;

    assert_exactly_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_acc |-> $countones({rom_drv, ram_drv}) == 1);
    assert_idle_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !win_acc |-> ({rom_drv, ram_drv} == '0));
    assert_zero_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_dout == '0) && !ram_dout);
endmodule

// File: tb/bank_cs_steer_tb.sv
`timescale 1ns/1ps
module bank_cs_steer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_wr = 1'b0;
    logic [3:0] bank_wdata = '0;
    logic       win_acc = 1'b0;
    logic [3:0] cfg_ram = '0;
    logic [3:0] rom_drv, rom_dout;
    logic       ram_drv, ram_dout;
    logic [3:0] ram_bank;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] cur_bank = '0;

    always #2.5 clk = ~clk;

    bank_cs_steer u_dut (
        .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_wdata(bank_wdata),
        .win_acc(win_acc), .cfg_ram(cfg_ram), .rom_drv(rom_drv), .rom_dout(rom_dout),
        .ram_drv(ram_drv), .ram_dout(ram_dout), .ram_bank(ram_bank)
    );

    // reference: expected {rom[3:0], ram} drive flags
    function automatic logic [4:0] exp_drv(input logic [3:0] b, input logic [3:0] c, input logic w);
        logic [4:0] r = '0;
        if (w) begin
            if (b >= 4)            r[0] = 1'b1;
            else if (c[b[1:0]])    r[0] = 1'b1;
            else                   r[b[1:0] + 1] = 1'b1;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (bank %0d cfg %b win %b)",
                     req, act, exp, cur_bank, cfg_ram, win_acc);
        end
    endtask

    task automatic write_bank(input logic [3:0] v);
        @(negedge clk);
        bank_wr = 1'b1; bank_wdata = v;
        @(negedge clk);
        bank_wr = 1'b0; bank_wdata = ~v;
        cur_bank = v;
    endtask

    task automatic check_outputs(input string req);
        logic [4:0] e;
        logic [4:0] pins;
        logic [4:0] epins;
        #1;
        e = exp_drv(cur_bank, cfg_ram, win_acc);
        chk(req, {27'd0, rom_drv, ram_drv}, {27'd0, e});
        pins  = {rom_drv ? ~rom_drv | rom_dout : 4'hF, 1'b0};
        for (int k = 0; k < 4; k++) pins[k+1] = rom_drv[k] ? rom_dout[k] : 1'b1;
        pins[0] = ram_drv ? ram_dout : 1'b1;
        epins = ~e;
        chk("R8", {27'd0, pins}, {27'd0, epins});
        chk("R7", $countones({rom_drv, ram_drv}), win_acc ? 1 : 0);
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20220726));
        repeat (3) @(negedge clk);
        #1;
        chk("R1", {28'd0, ram_bank}, 32'd0);
        chk("R3", {27'd0, rom_drv, ram_drv}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", {28'd0, ram_bank}, 32'd0);

        // full sweep: every bank x every config, active and idle
        for (int b = 0; b < 16; b++) begin
            write_bank(4'(b));
            #1;
            chk("R2", {28'd0, ram_bank}, b);
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                cfg_ram = 4'(c); win_acc = 1'b1;
                if (b >= 4)                   check_outputs("R4");
                else if (((c >> b) & 1) != 0) check_outputs("R6");
                else                          check_outputs("R5");
                @(negedge clk);
                win_acc = 1'b0;
                check_outputs("R3");
            end
        end

        // R9: other banks' config bits toggled, own bit fixed
        for (int b = 0; b < 4; b++) begin
            write_bank(4'(b));
            for (int own = 0; own < 2; own++) begin
                for (int c = 0; c < 16; c++) begin
                    @(negedge clk);
                    cfg_ram = 4'(c);
                    cfg_ram[b] = own[0];
                    win_acc = 1'b1;
                    check_outputs("R9");
                end
            end
        end
        @(negedge clk); win_acc = 1'b0;

        // R2 hold: no write keeps value
        write_bank(4'hA);
        repeat (3) begin
            @(negedge clk);
            bank_wdata = 4'(($urandom) & 32'hF);
            #1;
            chk("R2", {28'd0, ram_bank}, 32'hA);
        end

        // random traffic
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            win_acc = 1'b0;
            if (($urandom % 4) == 0) begin
                bank_wr = 1'b1;
                bank_wdata = 4'($urandom);
                @(negedge clk);
                bank_wr = 1'b0;
                cur_bank = bank_wdata;
                #1;
                chk("R2", {28'd0, ram_bank}, {28'd0, cur_bank});
            end
            cfg_ram = 4'($urandom);
            win_acc = ($urandom % 3) != 0;
            check_outputs(win_acc ? "R7" : "R3");
        end

        @(negedge clk); win_acc = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule